// File: doc/BRIEF.md
# Sink-Side Port Selector with Hot-Plug Fan-Out

This block is the control core of a three-input, one-output display switch that sits at the receiving end. It reads two select pins and an active-low low-power pin and turns them into a power mode, a one-hot choice of source port, and the termination enables for the three input ports. It routes the sink's DDC clock and data to the chosen port only. It also turns the single sink hot-plug level into one hot-plug output per source port. The analog receivers, the true bidirectional DDC buffering and the pads are outside the block. They are represented as pull-low enables and output-enable signals.

The pins pass through a two-stage synchroniser, and a mode state machine then decodes them. The state machine has five states: `ST_LOWPWR`, `ST_STANDBY`, `ST_PORT1`, `ST_PORT2` and `ST_PORT3`. On every clock it moves from whatever state it is in to the state that the current request decodes to. A low on the synchronised low-power pin leads to `ST_LOWPWR`. Otherwise the effective select code leads to one of the other four states: 11 to `ST_PORT1`, 10 to `ST_PORT2`, 00 to `ST_PORT3` and 01 to `ST_STANDBY`. A register-block override can replace the pin select with a two-bit register select that uses the same codes.

On the DDC lines, an `*_in` input carries the level seen on an open-drain line, where 1 means released. A `*_pull` output set to 1 means "drive that line low".

Top module: `hdmi_port_router`

## Requirements
- R1: The effective select code picks the port in `port_sel`, with bit 0 standing for port 1: code 11 gives 001, code 10 gives 010 and code 00 gives 100. Code 01 gives 000 (standby). `pwr_mode` reads 2 in normal mode, 1 in standby and 0 in low power.
- R2: `term_en` enables only the chosen port's termination. It is 000 in standby and in low power.
- R3: `src_scl_pull[p]` equals `~sink_scl_in` for the chosen port p and 0 for every other port. `src_sda_pull` behaves the same way with `sink_sda_in`.
- R4: `sink_scl_pull` is 1 only when the chosen port's `src_scl_in` is low, and likewise `sink_sda_pull` with `src_sda_in`. Levels on unselected ports have no effect on these outputs.
- R5: In normal mode the chosen port's `hpd_out` bit follows `hpd_sink`, and the other two bits are 0.
- R6: In standby all three `hpd_out` bits follow `hpd_sink`.
- R7: While the synchronised low-power pin is low, every output is 0, including `hpd_oe`, which means high impedance. The select pins and the override inputs have no effect during this time.
- R8: During reset and afterwards, the block is in standby (`pwr_mode`=1, `port_sel`=000, `hpd_oe`=111). The synchroniser resets to low-power-pin high and select code 01.
- R9: A change on `sel_pin` or `lp_n_pin` reaches the outputs after the third rising clock edge that follows it.
- R10: When `ovr_en` is 1, `ovr_sel` replaces the pins' select code, with the same encoding, and takes effect after the next rising edge. The low-power pin still has priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pin | input | 2 | Select pins, with bit 1 the upper select |
| lp_n_pin | input | 1 | Low-power pin, active low |
| ovr_en | input | 1 | Register override enable |
| ovr_sel | input | 2 | Register select code |
| hpd_sink | input | 1 | Sink hot-plug level |
| sink_scl_in | input | 1 | Sink-side DDC clock level |
| sink_sda_in | input | 1 | Sink-side DDC data level |
| src_scl_in | input | 3 | Source-side DDC clock levels, one per port |
| src_sda_in | input | 3 | Source-side DDC data levels, one per port |
| port_sel | output | 3 | One-hot chosen port |
| term_en | output | 3 | Input termination enables |
| pwr_mode | output | 2 | 0 low power, 1 standby, 2 normal |
| hpd_out | output | 3 | Hot-plug level per source port |
| hpd_oe | output | 3 | Hot-plug output enables (0 = high impedance) |
| src_scl_pull | output | 3 | Pull a source port's DDC clock low |
| src_sda_pull | output | 3 | Pull a source port's DDC data low |
| sink_scl_pull | output | 1 | Pull the sink DDC clock low |
| sink_sda_pull | output | 1 | Pull the sink DDC data low |

## Verification
A mode transition and a change of the sink hot-plug or DDC level can fall in the same cycle. In that cycle the new state decides which ports see the fresh level. The bench provokes this with long stretches of random stimulus, where select, low-power, override, hot-plug and DDC inputs all change on the same falling edge. It then judges every cycle against a behavioural model that keeps its own two-deep pin history. The override and the low-power pin are also made to collide, which checks that low power wins.

// File: rtl/hdmi_router_pkg.sv
package hdmi_router_pkg;
    typedef enum logic [2:0] {
        ST_LOWPWR  = 3'd0,
        ST_STANDBY = 3'd1,
        ST_PORT1   = 3'd2,
        ST_PORT2   = 3'd3,
        ST_PORT3   = 3'd4
    } route_st_t;

    typedef enum logic [1:0] {
        PWR_LOW  = 2'd0,
        PWR_STBY = 2'd1,
        PWR_NORM = 2'd2
    } pwr_mode_t;

    localparam logic [1:0] CODE_P1   = 2'b11;
    localparam logic [1:0] CODE_P2   = 2'b10;
    localparam logic [1:0] CODE_P3   = 2'b00;
    localparam logic [1:0] CODE_STBY = 2'b01;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import hdmi_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_n_s,
    input  logic [1:0] sel_s,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    output route_st_t  state
);
    route_st_t  state_nxt;
    logic [1:0] eff_sel;

    assign eff_sel = ovr_en ? ovr_sel : sel_s;

    always_comb begin
        if (!lp_n_s) begin
            state_nxt = ST_LOWPWR;
        end else begin
            unique case (eff_sel)
                CODE_P1:   state_nxt = ST_PORT1;
                CODE_P2:   state_nxt = ST_PORT2;
                CODE_P3:   state_nxt = ST_PORT3;
                default:   state_nxt = ST_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STANDBY;
        else        state <= state_nxt;
    end

    // R7
    lp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_n_s |=> state == ST_LOWPWR);

    // R10
    ovr_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_n_s && ovr_en && ovr_sel == CODE_STBY) |=> state == ST_STANDBY);
endmodule

// File: rtl/port_fabric.sv
module port_fabric
    import hdmi_router_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  route_st_t            state,
    input  logic                 hpd_sink,
    input  logic                 sink_scl_in,
    input  logic                 sink_sda_in,
    input  logic [NUM_PORTS-1:0] src_scl_in,
    input  logic [NUM_PORTS-1:0] src_sda_in,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic [NUM_PORTS-1:0] term_en,
    output pwr_mode_t            pwr_mode,
    output logic [NUM_PORTS-1:0] hpd_out,
    output logic [NUM_PORTS-1:0] hpd_oe,
    output logic [NUM_PORTS-1:0] src_scl_pull,
    output logic [NUM_PORTS-1:0] src_sda_pull,
    output logic                 sink_scl_pull,
    output logic                 sink_sda_pull
);
    logic [NUM_PORTS-1:0] chosen;
    logic                 powered;
    logic                 mirror_all;

    always_comb begin
        chosen     = '0;
        powered    = 1'b1;
        mirror_all = 1'b0;
        pwr_mode   = PWR_NORM;
        unique case (state)
            ST_LOWPWR:  begin powered = 1'b0; pwr_mode = PWR_LOW; end
            ST_STANDBY: begin mirror_all = 1'b1; pwr_mode = PWR_STBY; end
            ST_PORT1:   chosen[0] = 1'b1;
            ST_PORT2:   chosen[1] = 1'b1;
            ST_PORT3:   chosen[2] = 1'b1;
            default:    begin powered = 1'b0; pwr_mode = PWR_LOW; end
        endcase
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_sel[p]     = chosen[p];
        assign term_en[p]      = chosen[p];
        assign hpd_oe[p]       = powered;
        assign hpd_out[p]      = hpd_sink & (mirror_all | chosen[p]);
        assign src_scl_pull[p] = chosen[p] & ~sink_scl_in;
        assign src_sda_pull[p] = chosen[p] & ~sink_sda_in;
    end

    assign sink_scl_pull = |(chosen & ~src_scl_in);
    assign sink_sda_pull = |(chosen & ~src_sda_in);

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));

    // R5
    hpd_unsel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PWR_NORM) |-> ((hpd_out & ~port_sel) == '0));

    // R6
    stby_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PWR_STBY) |-> (hpd_out == {NUM_PORTS{hpd_sink}}));

    // R7
    lowpwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PWR_LOW) |-> (hpd_oe == '0 && term_en == '0 &&
                                   src_scl_pull == '0 && !sink_sda_pull));
endmodule

// File: rtl/hdmi_port_router.sv
module hdmi_port_router
    import hdmi_router_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_pin,
    input  logic       lp_n_pin,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    input  logic       hpd_sink,
    input  logic       sink_scl_in,
    input  logic       sink_sda_in,
    input  logic [2:0] src_scl_in,
    input  logic [2:0] src_sda_in,
    output logic [2:0] port_sel,
    output logic [2:0] term_en,
    output logic [1:0] pwr_mode,
    output logic [2:0] hpd_out,
    output logic [2:0] hpd_oe,
    output logic [2:0] src_scl_pull,
    output logic [2:0] src_sda_pull,
    output logic       sink_scl_pull,
    output logic       sink_sda_pull
);
    localparam int NUM_PORTS = 3;
    localparam int PIN_W     = 3;

    logic [PIN_W-1:0] pins_s;
    route_st_t        state;
    pwr_mode_t        pm;

    pin_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({1'b1, CODE_STBY})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lp_n_pin, sel_pin}),
        .q     (pins_s)
    );

    mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lp_n_s  (pins_s[2]),
        .sel_s   (pins_s[1:0]),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .state   (state)
    );

    port_fabric #(.NUM_PORTS(NUM_PORTS)) u_fabric (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .hpd_sink      (hpd_sink),
        .sink_scl_in   (sink_scl_in),
        .sink_sda_in   (sink_sda_in),
        .src_scl_in    (src_scl_in),
        .src_sda_in    (src_sda_in),
        .port_sel      (port_sel),
        .term_en       (term_en),
        .pwr_mode      (pm),
        .hpd_out       (hpd_out),
        .hpd_oe        (hpd_oe),
        .src_scl_pull  (src_scl_pull),
        .src_sda_pull  (src_sda_pull),
        .sink_scl_pull (sink_scl_pull),
        .sink_sda_pull (sink_sda_pull)
    );

    assign pwr_mode = pm;
endmodule

// File: tb/hdmi_port_router_test.sv
`timescale 1ns/1ps
module hdmi_port_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_pin = 2'b11;
    logic       lp_n_pin = 1'b1;
    logic       ovr_en = 1'b0;
    logic [1:0] ovr_sel = 2'b00;
    logic       hpd_sink = 1'b0;
    logic       sink_scl_in = 1'b1;
    logic       sink_sda_in = 1'b1;
    logic [2:0] src_scl_in = 3'b111;
    logic [2:0] src_sda_in = 3'b111;
    logic [2:0] port_sel, term_en, hpd_out, hpd_oe, src_scl_pull, src_sda_pull;
    logic [1:0] pwr_mode;
    logic       sink_scl_pull, sink_sda_pull;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hdmi_port_router uut (
        .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .lp_n_pin(lp_n_pin),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel), .hpd_sink(hpd_sink),
        .sink_scl_in(sink_scl_in), .sink_sda_in(sink_sda_in),
        .src_scl_in(src_scl_in), .src_sda_in(src_sda_in),
        .port_sel(port_sel), .term_en(term_en), .pwr_mode(pwr_mode),
        .hpd_out(hpd_out), .hpd_oe(hpd_oe), .src_scl_pull(src_scl_pull),
        .src_sda_pull(src_sda_pull), .sink_scl_pull(sink_scl_pull),
        .sink_sda_pull(sink_sda_pull)
    );

    // Reference model: 0 low power, 1 standby, 2..4 ports 1..3
    int         m_state = 1;
    logic [1:0] m_s1 = 2'b01, m_s2 = 2'b01;
    logic       m_l1 = 1'b1,  m_l2 = 1'b1;

    function automatic int decode(input logic lp, input logic [1:0] code);
        if (!lp) return 0;
        case (code)
            2'b11:   return 2;
            2'b10:   return 3;
            2'b00:   return 4;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 1; m_s1 = 2'b01; m_s2 = 2'b01; m_l1 = 1'b1; m_l2 = 1'b1;
        end else begin
            int nxt;
            nxt = decode(m_l2, ovr_en ? ovr_sel : m_s2);
            m_l2 = m_l1; m_s2 = m_s1;
            m_l1 = lp_n_pin; m_s1 = sel_pin;
            m_state = nxt;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [2:0] e_sel, e_hpd, e_oe;
        logic [1:0] e_pm;
        string t_sel, t_hpd, t_gen;
        e_sel = (m_state >= 2) ? 3'(1 << (m_state - 2)) : 3'b000;
        e_oe  = (m_state == 0) ? 3'b000 : 3'b111;
        e_pm  = (m_state == 0) ? 2'd0 : (m_state == 1) ? 2'd1 : 2'd2;
        e_hpd = (m_state == 0) ? 3'b000 :
                (m_state == 1) ? {3{hpd_sink}} : (e_sel & {3{hpd_sink}});
        t_gen = (m_state == 0) ? "R7" : "";
        t_sel = (m_state == 0) ? "R7" : (ovr_en ? "R10" : "R1");
        t_hpd = (m_state == 0) ? "R7" : (m_state == 1) ? "R6" : "R5";
        chk(t_sel, "port_sel", {1'b0, port_sel}, {1'b0, e_sel});
        chk(t_sel, "pwr_mode", {2'b0, pwr_mode}, {2'b0, e_pm});
        chk(m_state == 0 ? "R7" : "R2", "term_en", {1'b0, term_en}, {1'b0, e_sel});
        chk(t_hpd, "hpd_out", {1'b0, hpd_out}, {1'b0, e_hpd});
        chk(t_hpd, "hpd_oe", {1'b0, hpd_oe}, {1'b0, e_oe});
        chk(t_gen == "" ? "R3" : t_gen, "src_scl_pull", {1'b0, src_scl_pull},
            {1'b0, e_sel & {3{~sink_scl_in}}});
        chk(t_gen == "" ? "R3" : t_gen, "src_sda_pull", {1'b0, src_sda_pull},
            {1'b0, e_sel & {3{~sink_sda_in}}});
        chk(t_gen == "" ? "R4" : t_gen, "sink_scl_pull", {3'b0, sink_scl_pull},
            {3'b0, |(e_sel & ~src_scl_in)});
        chk(t_gen == "" ? "R4" : t_gen, "sink_sda_pull", {3'b0, sink_sda_pull},
            {3'b0, |(e_sel & ~src_sda_in)});
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) compare();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(100000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R8: reset state is standby
        chk("R8", "reset pwr_mode", {2'b0, pwr_mode}, 4'd1);
        chk("R8", "reset port_sel", {1'b0, port_sel}, 4'd0);
        chk("R8", "reset hpd_oe", {1'b0, hpd_oe}, 4'h7);
        rst_n = 1'b1;
        cyc(1);
        chk("R8", "post-reset pwr_mode", {2'b0, pwr_mode}, 4'd1);

        // port 1 with hot-plug and DDC activity
        sel_pin = 2'b11; cyc(4);
        hpd_sink = 1'b1; cyc(2);
        sink_scl_in = 1'b0; cyc(1);
        sink_sda_in = 1'b0; src_scl_in = 3'b110; cyc(2);
        src_scl_in = 3'b101; src_sda_in = 3'b011; cyc(2);
        sink_scl_in = 1'b1; sink_sda_in = 1'b1; src_scl_in = 3'b111; src_sda_in = 3'b111;

        // R9: latency of a pin change is three edges
        sel_pin = 2'b10;
        @(posedge clk); #2; chk("R9", "edge1 port_sel", {1'b0, port_sel}, 4'b0001);
        @(posedge clk); #2; chk("R9", "edge2 port_sel", {1'b0, port_sel}, 4'b0001);
        @(posedge clk); #2; chk("R9", "edge3 port_sel", {1'b0, port_sel}, 4'b0010);
        cyc(2);
        sel_pin = 2'b00; cyc(4);
        hpd_sink = 1'b0; cyc(1); hpd_sink = 1'b1; cyc(1);
        sel_pin = 2'b01; cyc(4);
        hpd_sink = 1'b0; cyc(2); hpd_sink = 1'b1; cyc(2);

        // R7: low power ignores select and override
        lp_n_pin = 1'b0; cyc(4);
        sel_pin = 2'b11; ovr_en = 1'b1; ovr_sel = 2'b10; sink_scl_in = 1'b0; cyc(4);
        chk("R7", "lp hpd_oe", {1'b0, hpd_oe}, 4'd0);
        ovr_en = 1'b0; sink_scl_in = 1'b1; lp_n_pin = 1'b1; cyc(4);

        // R10: override acts after one edge, same encoding
        ovr_en = 1'b1; ovr_sel = 2'b00;
        @(posedge clk); #2; chk("R10", "ovr port_sel", {1'b0, port_sel}, 4'b0100);
        cyc(1);
        for (int c = 0; c < 4; c++) begin
            ovr_sel = 2'(c); cyc(2);
        end
        ovr_en = 1'b0; cyc(4);

        // mixed stimulus: mode changes collide with hot-plug and DDC edges
        for (int i = 0; i < 600; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            sel_pin     = r[1:0];
            lp_n_pin    = (r[4:2] != 3'b000);
            ovr_en      = (r[6:5] == 2'b11);
            ovr_sel     = r[8:7];
            hpd_sink    = r[9];
            sink_scl_in = r[10];
            sink_sda_in = r[11];
            src_scl_in  = {r[12], r[13], r[14]};
            src_sda_in  = {r[15], r[12], r[10]};
            cyc(1 + int'(r[3]));
        end
        cyc(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule